// File: doc/BRIEF.md
# One-Hot Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator. It has separate program and data memories. Each instruction is two bytes. The first byte is an opcode in which exactly one bit is set. The second byte is either a one-hot selector for one of eight internal registers or, for the immediate instruction, a literal value. The external data RAM is always addressed by the accumulator. A program therefore loads the wanted address into the accumulator before it moves data between a register and memory.

Each instruction starts with a fetch cycle. In that cycle the core latches both instruction bytes from the program port, which returns the byte at the program address and the byte after it. An execute cycle follows. A load needs a third writeback cycle, because the data RAM returns read data one cycle after it sees the address. The only condition the core has is the accumulator sign bit, and only the jump instruction uses it. The accumulator and the program counter are visible on debug outputs.

Top module: `onehot_acc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, the accumulator and all eight registers become zero and the core enters its fetch cycle. `dmem_we` is low during reset.
- R2: An instruction that is not a load takes two cycles: fetch, then execute. A load takes three: fetch, execute, writeback. The program counter advances by 2, wrapping at 8 bits, when an instruction completes, unless a jump is taken.
- R3: Opcode 0x01 adds the selected register to the accumulator modulo 256. No carry is kept.
- R4: Opcode 0x02 writes the bitwise inverse of the selected register into the accumulator.
- R5: Opcode 0x04 copies the accumulator into the selected register. Opcode 0x08 copies the selected register into the accumulator.
- R6: Opcode 0x10 loads the second instruction byte into the accumulator.
- R7: Opcode 0x20 loads the selected register's value into the program counter when accumulator bit 7 is 1. Otherwise the program counter advances by 2.
- R8: Opcode 0x40 drives the accumulator on `dmem_addr` in the execute cycle. The data returned one cycle later is written into the selected register at the end of the writeback cycle.
- R9: Opcode 0x80 raises `dmem_we` for exactly the execute cycle. During that cycle `dmem_addr` equals the accumulator and `dmem_wdata` is the selected register.
- R10: An opcode byte that does not have exactly one bit set executes as a no-op. The accumulator, the registers and the data RAM are left unchanged, and the program counter advances by 2.
- R11: Operand bit n selects register n. An operand byte that does not have exactly one bit set reads as zero and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Byte address of the instruction to fetch (program counter) |
| prog_op | input | 8 | Program byte at `prog_addr` (opcode), read combinationally |
| prog_arg | input | 8 | Program byte at `prog_addr`+1 (operand), read combinationally |
| dmem_addr | output | 8 | Data RAM address, always equal to the accumulator |
| dmem_wdata | output | 8 | Data RAM write data (selected register) |
| dmem_we | output | 1 | Data RAM write enable |
| dmem_rdata | input | 8 | Data RAM read data, valid one cycle after the address |
| dbg_acc | output | 8 | Accumulator contents |
| dbg_pc | output | 8 | Program counter contents |

## Verification
The hardest case to reach from the ports is the one where the contents of a register depend on a load writeback, because no port shows the registers directly. The programs first load values from preset RAM locations into registers. They then copy those registers to the accumulator, add them, or store them back to RAM, so the value written in the writeback cycle becomes visible on `dbg_acc` or in RAM. Malformed operand bytes such as 0x00, 0x03 and 0x06 are placed next to later stores of the registers they could have hit, which shows that nothing was written. A taken jump over an immediate with a marker value shows that the skipped instruction had no effect.

// File: rtl/ohc_pkg.sv
package ohc_pkg;
   // Bit positions inside the one-hot opcode byte
   localparam int unsigned OPB_ADD   = 0;
   localparam int unsigned OPB_INV   = 1;
   localparam int unsigned OPB_SAVE  = 2;
   localparam int unsigned OPB_MOVE  = 3;
   localparam int unsigned OPB_IMM   = 4;
   localparam int unsigned OPB_JUMP  = 5;
   localparam int unsigned OPB_LOAD  = 6;
   localparam int unsigned OPB_STORE = 7;
   localparam int unsigned OP_COUNT  = 8;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_WB    = 2'd2
   } phase_t;
endpackage

// File: rtl/ohc_onehot_dec.sv
// Passes a byte through only when exactly one bit is set; otherwise all zero.
module ohc_onehot_dec #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] vec_i,
   output logic         valid_o,
   output logic [W-1:0] sel_o
);
   localparam int unsigned CW = $clog2(W + 1);

   initial begin
      if (W < 2) $error("ohc_onehot_dec: W must be at least 2");
   end

   logic [CW-1:0] ones;

   always_comb begin
      ones = '0;
      for (int unsigned i = 0; i < W; i++) begin
         ones = ones + CW'(vec_i[i]);
      end
   end

   assign valid_o = (ones == CW'(1));
   assign sel_o   = valid_o ? vec_i : '0;
endmodule

// File: rtl/ohc_regfile.sv
// Register file addressed by one-hot selects; an empty select reads zero.
module ohc_regfile #(
   parameter int unsigned DW       = 8,
   parameter int unsigned NREG     = 8,
   parameter bit          RF_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NREG-1:0] rsel_i,
   input  logic [NREG-1:0] wsel_i,
   input  logic            we_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   rdata_o
);
   logic [DW-1:0]   regs [NREG];
   logic [NREG-1:0] wen;

   assign wen = we_i ? wsel_i : '0;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (RF_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)         regs[g] <= '0;
            else if (wen[g]) regs[g] <= wdata_i;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (wen[g]) regs[g] <= wdata_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int unsigned i = 0; i < NREG; i++) begin
         rdata_o = rdata_o | (rsel_i[i] ? regs[i] : '0);
      end
   end

   // A malformed operand must never reach more than one register
   assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wen));
endmodule

// File: rtl/ohc_alu.sv
// Next-accumulator selection for the accumulator-writing opcodes.
module ohc_alu #(
   parameter int unsigned DW = 8
) (
   input  logic [ohc_pkg::OP_COUNT-1:0] op_sel_i,
   input  logic [DW-1:0]                acc_i,
   input  logic [DW-1:0]                rval_i,
   input  logic [DW-1:0]                imm_i,
   output logic [DW-1:0]                acc_o,
   output logic                         acc_we_o
);
   import ohc_pkg::*;

   logic [DW-1:0] sum;
   assign sum = acc_i + rval_i;

   always_comb begin
      acc_o = acc_i;
      unique case (1'b1)
         op_sel_i[OPB_ADD]:  acc_o = sum;
         op_sel_i[OPB_INV]:  acc_o = ~rval_i;
         op_sel_i[OPB_MOVE]: acc_o = rval_i;
         op_sel_i[OPB_IMM]:  acc_o = imm_i;
         default:            acc_o = acc_i;
      endcase
   end

   assign acc_we_o = op_sel_i[OPB_ADD] | op_sel_i[OPB_INV]
                   | op_sel_i[OPB_MOVE] | op_sel_i[OPB_IMM];
endmodule

// File: rtl/onehot_acc_core.sv
module onehot_acc_core #(
   parameter int unsigned DW       = 8,
   parameter int unsigned NREG     = 8,
   parameter bit          RF_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [DW-1:0] prog_addr,
   input  logic [DW-1:0] prog_op,
   input  logic [DW-1:0] prog_arg,
   output logic [DW-1:0] dmem_addr,
   output logic [DW-1:0] dmem_wdata,
   output logic          dmem_we,
   input  logic [DW-1:0] dmem_rdata,
   output logic [DW-1:0] dbg_acc,
   output logic [DW-1:0] dbg_pc
);
   import ohc_pkg::*;

   localparam logic [DW-1:0] PC_STEP = DW'(2);

   initial begin
      if (DW != OP_COUNT) $error("onehot_acc_core: DW must equal the opcode count");
      if (NREG != DW)     $error("onehot_acc_core: NREG must equal DW");
   end

   phase_t        state;
   logic [DW-1:0] pc, acc, ir_op, ir_arg;

   logic                op_ok, arg_ok;
   logic [DW-1:0]       op_sel_raw;
   logic [NREG-1:0]     reg_sel;
   logic [OP_COUNT-1:0] op_sel;
   logic [DW-1:0]       rval, acc_nxt;
   logic                acc_we, in_exec, in_wb, jump_taken;
   logic                rf_we;
   logic [DW-1:0]       rf_wdata;

   ohc_onehot_dec #(.W(DW)) i_op_dec (
      .vec_i(ir_op), .valid_o(op_ok), .sel_o(op_sel_raw)
   );
   ohc_onehot_dec #(.W(NREG)) i_arg_dec (
      .vec_i(ir_arg[NREG-1:0]), .valid_o(arg_ok), .sel_o(reg_sel)
   );

   assign in_exec = (state == ST_EXEC);
   assign in_wb   = (state == ST_WB);
   assign op_sel  = in_exec ? op_sel_raw[OP_COUNT-1:0] : '0;

   assign rf_we    = op_sel[OPB_SAVE] | in_wb;
   assign rf_wdata = in_wb ? dmem_rdata : acc;

   ohc_regfile #(.DW(DW), .NREG(NREG), .RF_RESET(RF_RESET)) i_rf (
      .clk(clk), .rst(rst),
      .rsel_i(reg_sel), .wsel_i(reg_sel),
      .we_i(rf_we), .wdata_i(rf_wdata), .rdata_o(rval)
   );

   ohc_alu #(.DW(DW)) i_alu (
      .op_sel_i(op_sel), .acc_i(acc), .rval_i(rval), .imm_i(ir_arg),
      .acc_o(acc_nxt), .acc_we_o(acc_we)
   );

   assign jump_taken = op_sel[OPB_JUMP] & acc[DW-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_FETCH;
         pc     <= '0;
         acc    <= '0;
         ir_op  <= '0;
         ir_arg <= '0;
      end else begin
         unique case (state)
            ST_FETCH: begin
               ir_op  <= prog_op;
               ir_arg <= prog_arg;
               state  <= ST_EXEC;
            end
            ST_EXEC: begin
               if (acc_we) acc <= acc_nxt;
               if (op_sel[OPB_LOAD]) begin
                  state <= ST_WB;
               end else begin
                  state <= ST_FETCH;
                  pc    <= jump_taken ? rval : pc + PC_STEP;
               end
            end
            ST_WB: begin
               state <= ST_FETCH;
               pc    <= pc + PC_STEP;
            end
            default: state <= ST_FETCH;
         endcase
      end
   end

   assign prog_addr  = pc;
   assign dmem_addr  = acc;
   assign dmem_wdata = rval;
   assign dmem_we    = op_sel[OPB_STORE];
   assign dbg_acc    = acc;
   assign dbg_pc     = pc;

   // Fetch only latches the instruction
   assert_fetch_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (pc == $past(pc)) && (acc == $past(acc)));
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      (in_exec && !op_sel[OPB_LOAD] && !jump_taken) |=> (pc == DW'($past(pc) + PC_STEP)));
   assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
      jump_taken |=> (pc == $past(rval)) && (state == ST_FETCH));
   assert_load_wb_R8: assert property (@(posedge clk) disable iff (rst)
      (in_exec && op_sel[OPB_LOAD]) |=> in_wb && $stable(pc));
   assert_wb_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
      in_wb |=> $stable(acc));
   assert_store_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      dmem_we |=> !dmem_we);
   assert_noop_R10: assert property (@(posedge clk) disable iff (rst)
      (in_exec && !op_ok) |=> $stable(acc) && !$past(dmem_we) && !$past(rf_we));
   assert_bad_arg_R11: assert property (@(posedge clk) disable iff (rst)
      (in_exec && !arg_ok) |-> (rval == '0));
endmodule

// File: tb/test_onehot_acc_core.sv
module test_onehot_acc_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] prog_addr, prog_op, prog_arg;
   logic [7:0] dmem_addr, dmem_wdata, dmem_rdata, dbg_acc, dbg_pc;
   logic       dmem_we;

   always #2.5 clk = ~clk;   // 200 MHz

   onehot_acc_core i_onehot_acc_core (
      .clk(clk), .rst(rst),
      .prog_addr(prog_addr), .prog_op(prog_op), .prog_arg(prog_arg),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc)
   );

   logic [7:0] prog [256];
   logic [7:0] ram  [256];
   logic [7:0] pnext;

   assign pnext    = prog_addr + 8'd1;
   assign prog_op  = prog[prog_addr];
   assign prog_arg = prog[pnext];

   always @(posedge clk) begin
      if (dmem_we) ram[dmem_addr] <= dmem_wdata;
      dmem_rdata <= ram[dmem_addr];
   end

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;
   bit done   = 1'b0;

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_pc, m_acc, m_op, m_arg, m_ld;
   logic [7:0] m_reg [8];
   logic [7:0] m_mem [256];
   int         m_phase;
   string      m_tag = "R1";

   function automatic bit oh(input logic [7:0] v);
      return $countones(v) == 1;
   endfunction

   function automatic int idx(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_pc = 0; m_acc = 0; m_phase = 0; m_op = 0; m_arg = 0;
         for (int i = 0; i < 8; i++) m_reg[i] = 0;
      end else begin
         case (m_phase)
            0: begin
               m_op = prog[m_pc];
               m_arg = prog[8'(m_pc + 8'd1)];
               m_phase = 1;
            end
            1: begin
               logic [7:0] rv, nxt;
               rv = oh(m_arg) ? m_reg[idx(m_arg)] : 8'h00;
               nxt = m_pc + 8'd2;
               m_phase = 0;
               if (!oh(m_op)) m_tag = "R10";
               else case (m_op)
                  8'h01: begin m_acc = m_acc + rv; m_tag = "R3"; end
                  8'h02: begin m_acc = ~rv; m_tag = "R4"; end
                  8'h04: begin if (oh(m_arg)) m_reg[idx(m_arg)] = m_acc; m_tag = "R5"; end
                  8'h08: begin m_acc = rv; m_tag = "R5"; end
                  8'h10: begin m_acc = m_arg; m_tag = "R6"; end
                  8'h20: begin if (m_acc[7]) nxt = rv; m_tag = "R7"; end
                  8'h40: begin m_ld = m_mem[m_acc]; m_phase = 2; m_tag = "R8"; end
                  default: begin m_mem[m_acc] = rv; m_tag = "R9"; end
               endcase
               if (m_phase != 2) m_pc = nxt;
            end
            default: begin
               if (oh(m_arg)) m_reg[idx(m_arg)] = m_ld;
               m_pc = m_pc + 8'd2;
               m_phase = 0;
            end
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (cmp_en && !rst) begin
         chk(dbg_pc == m_pc, "R2 program counter", dbg_pc, m_pc);
         chk(dbg_acc == m_acc, m_tag, dbg_acc, m_acc);
         chk(dmem_we == (m_phase == 1 && m_op == 8'h80), "R9 write enable",
             dmem_we, (m_phase == 1 && m_op == 8'h80));
         if (dmem_we) begin
            chk(dmem_addr == m_acc, "R9 store address", dmem_addr, m_acc);
            chk(dmem_wdata == (oh(m_arg) ? m_reg[idx(m_arg)] : 8'h00),
                "R11 store data", dmem_wdata, oh(m_arg) ? m_reg[idx(m_arg)] : 8'h00);
         end
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=<5000", cycles);
         summary();
      end
   end

   task automatic put(input int a, input logic [7:0] op, input logic [7:0] arg);
      prog[a] = op;
      prog[a+1] = arg;
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = 8'h00;
   endtask

   task automatic preset(input int a, input logic [7:0] v);
      ram[a] = v;
      m_mem[a] = v;
   endtask

   task automatic start_run(input int n);
      @(negedge clk);
      rst = 1'b1;
      cmp_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(dbg_pc == 8'h00, "R1 pc after reset", dbg_pc, 0);
      chk(dbg_acc == 8'h00, "R1 acc after reset", dbg_acc, 0);
      chk(dmem_we == 1'b0, "R1 write enable in reset", dmem_we, 0);
      rst = 1'b0;
      cmp_en = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   bit saw55 = 1'b0;
   always @(negedge clk) if (cmp_en && dbg_acc == 8'h55) saw55 = 1'b1;

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram[i] = 8'(i * 7 + 3);
         m_mem[i] = 8'(i * 7 + 3);
      end

      // Test 1: arithmetic, inverse, save/move, store, load
      clear_prog();
      put(0, 8'h10, 8'h7F); put(2, 8'h04, 8'h01); put(4, 8'h10, 8'h90);
      put(6, 8'h01, 8'h01); put(8, 8'h04, 8'h02); put(10, 8'h02, 8'h02);
      put(12, 8'h04, 8'h04); put(14, 8'h10, 8'h20); put(16, 8'h80, 8'h04);
      put(18, 8'h08, 8'h01); put(20, 8'h10, 8'h21); put(22, 8'h80, 8'h02);
      put(24, 8'h40, 8'h08); put(26, 8'h10, 8'h22); put(28, 8'h80, 8'h08);
      start_run(40);
      chk(ram[8'h20] == 8'hF0, "R4 inverse stored", ram[8'h20], 8'hF0);
      chk(ram[8'h21] == 8'h0F, "R3 wrapped sum stored", ram[8'h21], 8'h0F);
      chk(ram[8'h22] == 8'h0F, "R8 loaded register stored", ram[8'h22], 8'h0F);
      chk(dbg_acc == 8'h22, "R6 final immediate", dbg_acc, 8'h22);

      // Test 2: jumps, malformed opcode and operands
      clear_prog();
      preset(8'h30, 8'hAA); preset(8'h31, 8'hAA); preset(8'h32, 8'hAA);
      put(0, 8'h10, 8'h0E); put(2, 8'h04, 8'h10); put(4, 8'h10, 8'h7F);
      put(6, 8'h20, 8'h10); put(8, 8'h10, 8'h80); put(10, 8'h20, 8'h10);
      put(12, 8'h10, 8'h55); put(14, 8'h03, 8'h01); put(16, 8'h04, 8'h20);
      put(18, 8'h10, 8'h30); put(20, 8'h80, 8'h03); put(22, 8'h08, 8'h00);
      put(24, 8'h10, 8'h99); put(26, 8'h04, 8'h06); put(28, 8'h10, 8'h31);
      put(30, 8'h80, 8'h02); put(32, 8'h10, 8'h32); put(34, 8'h80, 8'h20);
      saw55 = 1'b0;
      start_run(50);
      chk(saw55 == 1'b0, "R7 skipped instruction executed", saw55, 0);
      chk(ram[8'h32] == 8'h80, "R10 no-op kept accumulator", ram[8'h32], 8'h80);
      chk(ram[8'h30] == 8'h00, "R11 bad operand reads zero", ram[8'h30], 8'h00);
      chk(ram[8'h31] == 8'h00, "R11 bad operand wrote register", ram[8'h31], 8'h00);
      chk(dbg_acc == 8'h32, "R5 final accumulator", dbg_acc, 8'h32);

      // Test 3: load latency, load with malformed operand, wrap on add
      clear_prog();
      preset(8'h40, 8'h3C); preset(8'h41, 8'hC5);
      put(0, 8'h10, 8'h40); put(2, 8'h40, 8'h80); put(4, 8'h40, 8'h00);
      put(6, 8'h08, 8'h80); put(8, 8'h04, 8'h40); put(10, 8'h10, 8'h41);
      put(12, 8'h40, 8'h40); put(14, 8'h08, 8'h40); put(16, 8'h01, 8'h80);
      start_run(40);
      chk(dbg_acc == 8'h01, "R8 loaded values summed (R3 wrap)", dbg_acc, 8'h01);

      for (int i = 0; i < 256; i++)
         if (ram[i] != m_mem[i]) chk(1'b0, "R9 RAM image", ram[i], m_mem[i]);
      checks++;
      summary();
   end
endmodule